// File: doc/BRIEF.md
# Cartridge ROM Bank Controller

This block sits on the cartridge side of a CPU bus. It decides which 16 KiB bank of ROM appears in the upper half of the 32 KiB ROM address space. While reset is held, it latches a one-byte controller-type code from the cartridge header. That code picks one of several mapping behaviours, and it cannot change again until the next reset.

After reset, the CPU changes the bank by writing into the bank-select page of the ROM window. What happens to that write depends on the latched behaviour:
- It may take a 5-bit or a 7-bit bank field from the data.
- It may or may not turn a request for bank 0 into bank 1.
- A request for a bank beyond the ROM's configured size is always dropped.

For every read address, the block forms a physical ROM byte address:
- Lower window: bank 0 plus the 14-bit offset.
- Upper window: the current bank plus the offset.
- Anything above the ROM windows: zero.

Top module: `rom_bank_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the current bank becomes 1 and the type code is latched.
- R2: The latched type code selects the behaviour:
  - 0x00, 0x08, 0x09 select "plain".
  - 0x01–0x03 select "narrow".
  - 0x05–0x06 select "passive-A".
  - 0x0F–0x13 select "wide-remap".
  - 0x15–0x17 select "passive-B".
  - 0x19–0x1E and every other value select "wide-direct".
- R3: A write takes effect only when `wr_page` (CPU address bits 15:13) equals 1, i.e. addresses 0x2000–0x3FFF. Writes on any other page leave the bank unchanged.
- R4: For "narrow", the requested bank is built as follows:
  - Bits 4:0 are `wr_data[4:0]`, except that a value of 0 becomes 1.
  - Bits 6:5 are kept from the current bank.
- R5: For "wide-remap", the requested bank is `wr_data[6:0]`, except that 0 becomes 1.
- R6: For "wide-direct", the requested bank is `wr_data[6:0]`, and bank 0 is accepted.
- R7: A request for a bank greater than or equal to `ROM_BANKS` is dropped, and the current bank stays unchanged.
- R8: For "plain", "passive-A" and "passive-B", every write is ignored.
- R9: `rom_addr` is determined by `rd_addr` as follows:
  - For `rd_addr` 0x4000–0x7FFF: `rom_addr` = current bank × 16384 + `rd_addr[13:0]`.
  - For `rd_addr` below 0x4000: `rom_addr` = `rd_addr`.
  - For `rd_addr` 0x8000 and above: `rom_addr` = 0.
- R10: Changes of `hdr_type` while `rst_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; latches `hdr_type` |
| hdr_type | input | 8 | Cartridge controller-type code |
| wr_en | input | 1 | CPU write strobe into the ROM window |
| wr_page | input | 3 | CPU write address bits 15:13 |
| wr_data | input | 7 | CPU write data bits 6:0 |
| rd_addr | input | 16 | CPU read address |
| rom_addr | output | 21 | Physical ROM byte address |
| cur_bank | output | 7 | Current switchable bank |

## Verification
The rule in "narrow" mode that keeps bank bits 6:5 is the hardest to show from the ports. After reset those bits are zero, and no write can set them. The check therefore rests on a bank-select data value with bits 5 and 6 set, such as 0x65. That write must leave those bank bits at zero and land on bank 5.

To test range rejection in every mode, the bench uses a ROM of 24 banks. That size is not a power of two, so:
- The widest 5-bit request, 31, is refused.
- Requests of 23 and 24 probe the exact boundary.

// File: rtl/rom_bank_ctrl.sv
`timescale 1ns/1ps
module rom_bank_ctrl #(
  parameter int ROM_BANKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  hdr_type,
  input  logic        wr_en,
  input  logic [2:0]  wr_page,
  input  logic [6:0]  wr_data,
  input  logic [15:0] rd_addr,
  output logic [20:0] rom_addr,
  output logic [6:0]  cur_bank
);
  localparam int BANK_W = 7;
  localparam int OFS_W  = 14;

  typedef enum logic [2:0] {
    MAP_PLAIN, MAP_NARROW, MAP_PASS_A, MAP_WIDE_REMAP, MAP_PASS_B, MAP_WIDE_DIRECT
  } map_t;

  function automatic map_t decode(input logic [7:0] code);
    case (code)
      8'h00, 8'h08, 8'h09:               decode = MAP_PLAIN;
      8'h01, 8'h02, 8'h03:               decode = MAP_NARROW;
      8'h05, 8'h06:                      decode = MAP_PASS_A;
      8'h0F, 8'h10, 8'h11, 8'h12, 8'h13: decode = MAP_WIDE_REMAP;
      8'h15, 8'h16, 8'h17:               decode = MAP_PASS_B;
      default:                           decode = MAP_WIDE_DIRECT;
    endcase
  endfunction

  map_t              mode;
  logic [BANK_W-1:0] req;
  logic              takes;
  logic              wr_hit;
  logic              accept;

  assign wr_hit = wr_en && (wr_page == 3'd1);

  always_comb begin
    req   = '0;
    takes = 1'b0;
    case (mode)
      MAP_NARROW: begin
        req   = {cur_bank[6:5], (wr_data[4:0] == 5'd0) ? 5'd1 : wr_data[4:0]};
        takes = 1'b1;
      end
      MAP_WIDE_REMAP: begin
        req   = (wr_data == 7'd0) ? 7'd1 : wr_data;
        takes = 1'b1;
      end
      MAP_WIDE_DIRECT: begin
        req   = wr_data;
        takes = 1'b1;
      end
      default: ;
    endcase
  end

  assign accept = wr_hit && takes && (int'(req) < ROM_BANKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= decode(hdr_type);
      cur_bank <= BANK_W'(1);
    end else if (accept) begin
      cur_bank <= req;
    end
  end

  assign rom_addr = (rd_addr[15:14] == 2'b01) ? {cur_bank, rd_addr[OFS_W-1:0]} :
                    (rd_addr[15] == 1'b0)     ? {BANK_W'(0), rd_addr[OFS_W-1:0]} :
                                                '0;

  // R7
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_bank) < ROM_BANKS);

  // R4 R5
  no_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MAP_NARROW || mode == MAP_WIDE_REMAP) |-> cur_bank != 7'd0);

  // R3
  write_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cur_bank != $past(cur_bank)) |-> $past(wr_en && wr_page == 3'd1));

  // R8
  passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MAP_PLAIN || mode == MAP_PASS_A || mode == MAP_PASS_B) |=> $stable(cur_bank));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode == MAP_NARROW) |-> cur_bank[6:5] == $past(cur_bank[6:5]));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode));
endmodule

// File: tb/tb_rom_bank_ctrl.sv
`timescale 1ns/1ps
module tb_rom_bank_ctrl;
  localparam int NB = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hdr_type = 8'h00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_page = 3'd0;
  logic [6:0]  wr_data = 7'd0;
  logic [15:0] rd_addr = 16'h0000;
  logic [20:0] rom_addr;
  logic [6:0]  cur_bank;

  int checks = 0;
  int fails = 0;
  int m_var = 0;
  int m_bank = 1;
  int nb;
  bit started = 0;
  string tag = "R1";

  rom_bank_ctrl #(.ROM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .hdr_type(hdr_type), .wr_en(wr_en),
    .wr_page(wr_page), .wr_data(wr_data), .rd_addr(rd_addr),
    .rom_addr(rom_addr), .cur_bank(cur_bank));

  always #4 clk = ~clk;

  // 0 plain, 1 narrow, 2 passive-A, 3 wide-remap, 4 passive-B, 5 wide-direct
  function automatic int kind_of(input int c);
    if (c == 0 || c == 8 || c == 9) return 0;
    if (c >= 1 && c <= 3) return 1;
    if (c == 5 || c == 6) return 2;
    if (c >= 15 && c <= 19) return 3;
    if (c >= 21 && c <= 23) return 4;
    return 5;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_var  = kind_of(int'(hdr_type));
      m_bank = 1;
    end else if (wr_en && wr_page == 3'd1) begin
      nb = -1;
      if (m_var == 1) begin
        nb = int'(wr_data) % 32;
        if (nb == 0) nb = 1;
        nb = nb + (m_bank / 32) * 32;
      end else if (m_var == 3) begin
        nb = int'(wr_data);
        if (nb == 0) nb = 1;
      end else if (m_var == 5) begin
        nb = int'(wr_data);
      end
      if (nb >= 0 && nb < NB) m_bank = nb;
    end
  end

  always @(negedge clk) begin
    int exp_a;
    if (started) begin
      checks++;
      if (int'(cur_bank) != m_bank) begin
        fails++;
        $display("FAIL %s cur_bank actual=%0d expected=%0d", tag, cur_bank, m_bank);
      end
      if (rd_addr < 16'h4000) exp_a = int'(rd_addr);
      else if (rd_addr < 16'h8000) exp_a = m_bank * 16384 + int'(rd_addr) % 16384;
      else exp_a = 0;
      checks++;
      if (int'(rom_addr) != exp_a) begin
        fails++;
        $display("FAIL R9 rom_addr actual=%0h expected=%0h", rom_addr, exp_a);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic boot(input logic [7:0] code);
    tag = "R1";
    rst_n = 1'b0; hdr_type = code; wr_en = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tag = "R10";
    hdr_type = ~code;
    tick();
  endtask

  task automatic wr(input logic [2:0] pg, input logic [6:0] d, input string t);
    tag = t;
    wr_en = 1'b1; wr_page = pg; wr_data = d;
    tick();
    wr_en = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd_addr = 16'(a * 16'h3A71 + int'(d));
      tick();
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R2 narrow
    boot(8'h01);
    wr(3'd1, 7'h00, "R4");
    wr(3'd1, 7'h05, "R4");
    wr(3'd1, 7'h65, "R4");
    wr(3'd1, 7'h1F, "R7");
    wr(3'd1, 7'h17, "R7");
    wr(3'd0, 7'h09, "R3");
    wr(3'd2, 7'h09, "R3");
    wr(3'd7, 7'h02, "R3");
    // R2 wide-remap
    boot(8'h13);
    wr(3'd1, 7'h00, "R5");
    wr(3'd1, 7'h45, "R7");
    wr(3'd1, 7'h17, "R5");
    wr(3'd1, 7'h18, "R7");
    boot(8'h0F);
    wr(3'd1, 7'h0C, "R5");
    // R2 wide-direct
    boot(8'h1B);
    wr(3'd1, 7'h00, "R6");
    wr(3'd1, 7'h7F, "R7");
    wr(3'd1, 7'h0A, "R6");
    boot(8'h42);
    wr(3'd1, 7'h00, "R6");
    wr(3'd1, 7'h13, "R6");
    // R8 passive behaviours
    boot(8'h05);
    wr(3'd1, 7'h05, "R8");
    boot(8'h16);
    wr(3'd1, 7'h07, "R8");
    boot(8'h00);
    wr(3'd1, 7'h03, "R8");
    boot(8'h09);
    wr(3'd1, 7'h00, "R8");
    tag = "R9";
    for (int a = 0; a < 16; a++) begin
      rd_addr = 16'(a * 16'h1001);
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule